// File: doc/BRIEF.md
# Graphic LCD Write Strobe Controller

This block drives the write side of a parallel 128x64 graphic LCD. The panel is split into a left half and a right half, and each half has its own chip select. A host hands over one byte per request through a valid/ready handshake. With each byte it gives a flag that marks the byte as a command or as display data, and a 2-bit code that picks the target half. Commands set the page and column address registers. Data bytes carry graphics into the display RAM.

For each accepted request the block drives the register-select line, holds the read/write line at write, places the byte on the 8-bit bus and asserts the chip selects. It then produces a timed enable pulse: enable rises, stays high for a set number of clocks, falls, and then stays low for a set number of clocks. The panel latches the byte on the falling edge of enable. The two phase lengths come from parameters given in nanoseconds and the clock frequency. The defaults give 4 µs high and 4 µs low at 200 MHz, which suits noisy or high-inductance wiring. Setting them to 500 ns each meets the 1 µs minimum cycle. While a transfer runs, ready is low, so back-to-back requests can never shorten either phase.

Top module: `glcd_wr_strobe`

## Requirements
- R1: During and straight after reset: enable is 0, read/write is 0, both chip selects are 0 (inactive), and ready is 1.
- R2: A data request (is_data = 1) drives register-select to 1 and read/write to 0 for the whole transfer.
- R3: A command request (is_data = 0) drives register-select to 0 and read/write to 0 for the whole transfer.
- R4: Chip selects are active high. Half code 01 asserts cs1 only (left half), 10 asserts cs2 only (right half), and 11 asserts both, for the whole transfer.
- R5: A request with half code 00 completes the handshake but has no effect. No enable pulse follows, ready stays 1, and the bus, register-select and chip selects keep their previous values.
- R6: The bus, register-select and chip selects take their new values on the acceptance edge. They are stable for SETUP_CYC clocks (default 1) before enable rises. They do not change until the enable-low phase ends.
- R7: Enable is high for exactly ceil(CLK_FREQ_HZ*EN_HI_NS/1e9) clocks and then low for exactly ceil(CLK_FREQ_HZ*EN_LO_NS/1e9) clocks. The defaults give 800 and 800 at 200 MHz.
- R8: Ready falls on the acceptance edge and returns to 1 only after the enable-low phase has elapsed. Requests presented while ready is 0 have no effect on any output.
- R9: When a transfer ends, both chip selects return to 0. Register-select and the bus keep the last transfer's values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_data_i | input | 8 | Byte to write |
| req_is_data_i | input | 1 | 1 = display data, 0 = command |
| req_half_i | input | 2 | Half select: 01 left, 10 right, 11 both, 00 rejected |
| lcd_db_o | output | 8 | Panel data bus |
| lcd_rs_o | output | 1 | Register select (1 data, 0 command) |
| lcd_rw_o | output | 1 | Read/write, always 0 (write) |
| lcd_cs1_o | output | 1 | Left half chip select, active high |
| lcd_cs2_o | output | 1 | Right half chip select, active high |
| lcd_en_o | output | 1 | Enable strobe; panel latches on its falling edge |

## Verification
A wrong phase count shows up at the enable pin. The bench compares every cycle with a reference model, so a pulse that is one clock too long or too short is caught on the very clock where the edge lands off time. A sequencer stuck in the wrong state shows as ready disagreeing with enable within one clock of acceptance. A bus register that loads at the wrong moment shows as the bus or register-select changing during a transfer, or as a rejected or ignored request leaking onto the pins on the following clock.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_EN_HI = 2'd2,
    ST_EN_LO = 2'd3
  } glcd_state_e;

  localparam logic [1:0] HALF_NONE  = 2'b00;
  localparam logic [1:0] HALF_LEFT  = 2'b01;
  localparam logic [1:0] HALF_RIGHT = 2'b10;
  localparam logic [1:0] HALF_BOTH  = 2'b11;
endpackage

// File: rtl/glcd_req_check.sv
module glcd_req_check (
  input  logic [1:0] half_i,
  output logic       half_ok_o,
  output logic [1:0] cs_o
);
  import glcd_pkg::*;

  always_comb begin
    unique case (half_i)
      HALF_LEFT:  cs_o = 2'b01;
      HALF_RIGHT: cs_o = 2'b10;
      HALF_BOTH:  cs_o = 2'b11;
      default:    cs_o = 2'b00;
    endcase
    half_ok_o = (half_i != HALF_NONE);
  end
endmodule

// File: rtl/glcd_phase_timer.sv
module glcd_phase_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/glcd_bus_hold.sv
module glcd_bus_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clr_cs_i,
  input  logic [DW-1:0] db_i,
  input  logic          rs_i,
  input  logic [1:0]    cs_i,
  output logic [DW-1:0] db_o,
  output logic          rs_o,
  output logic [1:0]    cs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_o <= '0;
      rs_o <= 1'b0;
      cs_o <= 2'b00;
    end else if (load_i) begin
      db_o <= db_i;
      rs_o <= rs_i;
      cs_o <= cs_i;
    end else if (clr_cs_i) begin
      cs_o <= 2'b00;
    end
  end
endmodule

// File: rtl/glcd_wr_strobe.sv
module glcd_wr_strobe #(
  parameter longint unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned     EN_HI_NS    = 4000,
  parameter int unsigned     EN_LO_NS    = 4000,
  parameter int unsigned     SETUP_CYC   = 1,
  parameter int unsigned     DW          = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [DW-1:0] req_data_i,
  input  logic          req_is_data_i,
  input  logic [1:0]    req_half_i,
  output logic [DW-1:0] lcd_db_o,
  output logic          lcd_rs_o,
  output logic          lcd_rw_o,
  output logic          lcd_cs1_o,
  output logic          lcd_cs2_o,
  output logic          lcd_en_o
);
  import glcd_pkg::*;

  localparam longint unsigned HI_RAW = (CLK_FREQ_HZ * EN_HI_NS + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint unsigned LO_RAW = (CLK_FREQ_HZ * EN_LO_NS + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint unsigned HI_CYC = (HI_RAW == 0) ? 1 : HI_RAW;
  localparam longint unsigned LO_CYC = (LO_RAW == 0) ? 1 : LO_RAW;
  localparam longint unsigned SU_CYC = (SETUP_CYC == 0) ? 1 : SETUP_CYC;
  localparam longint unsigned MAX_CYC = (HI_CYC > LO_CYC) ? ((HI_CYC > SU_CYC) ? HI_CYC : SU_CYC)
                                                          : ((LO_CYC > SU_CYC) ? LO_CYC : SU_CYC);
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  glcd_state_e      st_q, st_d;
  logic             en_q;
  logic             half_ok;
  logic [1:0]       cs_dec, cs_q;
  logic             accept;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             clr_cs;

  glcd_req_check u_req_check (
    .half_i    (req_half_i),
    .half_ok_o (half_ok),
    .cs_o      (cs_dec)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o && half_ok;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    clr_cs   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d     = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SU_CYC - 1);
      end
      ST_SETUP: if (tmr_done) begin
        st_d     = ST_EN_HI;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HI_CYC - 1);
      end
      ST_EN_HI: if (tmr_done) begin
        st_d     = ST_EN_LO;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LO_CYC - 1);
      end
      ST_EN_LO: if (tmr_done) begin
        st_d   = ST_IDLE;
        clr_cs = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= (st_d == ST_EN_HI);
    end
  end

  glcd_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  glcd_bus_hold #(.DW(DW)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .clr_cs_i (clr_cs),
    .db_i     (req_data_i),
    .rs_i     (req_is_data_i),
    .cs_i     (cs_dec),
    .db_o     (lcd_db_o),
    .rs_o     (lcd_rs_o),
    .cs_o     (cs_q)
  );

  assign lcd_cs1_o = cs_q[0];
  assign lcd_cs2_o = cs_q[1];
  assign lcd_rw_o  = 1'b0;
  assign lcd_en_o  = en_q;

  // R6: bus side frozen while enable is high and through the low phase
  a_r6_bus_stable_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_en_o |-> ($stable(lcd_db_o) && $stable(lcd_rs_o) && $stable(cs_q)));
  a_r6_bus_stable_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EN_LO && $past(st_q) != ST_IDLE) |-> ($stable(lcd_db_o) && $stable(lcd_rs_o)));
  // R6: enable only rises after at least one busy setup clock
  a_r6_setup_before_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_en_o) |-> $past(!req_ready_o));
  // R4: some half is selected whenever enable rises
  a_r4_cs_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_en_o) |-> (lcd_cs1_o || lcd_cs2_o));
  // R8: busy implies a selected half, idle implies enable low
  a_r8_busy_has_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (lcd_cs1_o || lcd_cs2_o));
  a_r8_idle_en_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !lcd_en_o);
  // R5: a rejected half code leaves ready high
  a_r5_reject_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && req_half_i == 2'b00) |=> req_ready_o);
endmodule

// File: tb/glcd_wr_strobe_bench.sv
module glcd_wr_strobe_bench;
  localparam int HI = 800;
  localparam int LO = 800;
  localparam int SU = 1;
  localparam int TOTAL = SU + HI + LO;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [7:0] req_data_i = 8'h00;
  logic       req_is_data_i = 1'b0;
  logic [1:0] req_half_i = 2'b00;
  logic [7:0] lcd_db_o;
  logic       lcd_rs_o, lcd_rw_o, lcd_cs1_o, lcd_cs2_o, lcd_en_o;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  glcd_wr_strobe #(
    .CLK_FREQ_HZ(200_000_000), .EN_HI_NS(4000), .EN_LO_NS(4000), .SETUP_CYC(SU), .DW(8)
  ) u_glcd_wr_strobe (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_data_i, .req_is_data_i,
    .req_half_i, .lcd_db_o, .lcd_rs_o, .lcd_rw_o, .lcd_cs1_o, .lcd_cs2_o, .lcd_en_o
  );

  // reference model
  bit       m_busy = 0;
  int       m_t = 0;
  bit       m_rs = 0;
  bit [7:0] m_db = 0;
  bit       m_cs1 = 0, m_cs2 = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 0; m_t <= 0; m_rs <= 0; m_db <= 0; m_cs1 <= 0; m_cs2 <= 0;
    end else if (!m_busy) begin
      if (req_valid_i && req_half_i != 2'b00) begin
        m_busy <= 1; m_t <= 0;
        m_rs <= req_is_data_i; m_db <= req_data_i;
        m_cs1 <= req_half_i[0]; m_cs2 <= req_half_i[1];
      end
    end else if (m_t == TOTAL - 1) begin
      m_busy <= 0; m_cs1 <= 0; m_cs2 <= 0;
    end else begin
      m_t <= m_t + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    cyc++;
    if (chk_en) begin
      bit en_exp;
      en_exp = m_busy && m_t >= SU && m_t < SU + HI;
      chk("R7", "enable", lcd_en_o, en_exp);
      chk("R8", "ready", req_ready_o, !m_busy);
      chk("R3", "read/write", lcd_rw_o, 0);
      chk(m_rs ? "R2" : "R3", "register-select", lcd_rs_o, m_rs);
      chk("R6", "bus", lcd_db_o, m_db);
      chk("R4", "cs1", lcd_cs1_o, m_cs1);
      chk("R4", "cs2", lcd_cs2_o, m_cs2);
    end
  end

  // R7: directed width measurement on the enable pin
  int hi_run = 0, lo_run = 0;
  bit seen_fall = 0;
  always @(negedge clk_i) begin
    if (chk_en) begin
      if (lcd_en_o) begin
        hi_run++;
        if (seen_fall) begin chk("R7", "low width", lo_run, LO); seen_fall = 0; end
      end else if (hi_run != 0) begin
        chk("R7", "high width", hi_run, HI);
        hi_run = 0; lo_run = 1; seen_fall = 1;
      end else if (seen_fall) begin
        if (req_ready_o) begin chk("R7", "low width", lo_run, LO); seen_fall = 0; end
        else lo_run++;
      end
    end
  end

  task automatic send(input bit is_data, input bit [1:0] half, input bit [7:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_is_data_i = is_data; req_half_i = half; req_data_i = d;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
  endtask

  task automatic drop();
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (!req_ready_o);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1", "reset enable", lcd_en_o, 0);
    chk("R1", "reset rw", lcd_rw_o, 0);
    chk("R1", "reset cs1", lcd_cs1_o, 0);
    chk("R1", "reset cs2", lcd_cs2_o, 0);
    chk("R1", "reset ready", req_ready_o, 1);
    rst_ni = 1;
    chk_en = 1;
    @(negedge clk_i);
    chk("R1", "ready after reset", req_ready_o, 1);

    send(1, 2'b01, 8'hA5); drop(); wait_idle();        // R2 data, left
    chk("R9", "cs1 after end", lcd_cs1_o, 0);
    chk("R9", "rs held", lcd_rs_o, 1);
    chk("R9", "db held", lcd_db_o, 8'hA5);
    send(0, 2'b11, 8'hB8); drop(); wait_idle();        // R3 command, both
    send(1, 2'b10, 8'h3C); drop(); wait_idle();        // R4 right half
    send(0, 2'b00, 8'hFF); drop();                     // R5 rejected
    @(negedge clk_i);
    chk("R5", "no pulse ready", req_ready_o, 1);
    chk("R5", "bus unchanged", lcd_db_o, 8'h3C);
    chk("R5", "rs unchanged", lcd_rs_o, 1);
    // R8: back-to-back; valid held, payload changes while busy
    send(0, 2'b01, 8'h40);
    @(negedge clk_i);
    req_is_data_i = 1; req_half_i = 2'b10; req_data_i = 8'h99;
    repeat (20) @(negedge clk_i);
    chk("R8", "busy ignores bus", lcd_db_o, 8'h40);
    send(1, 2'b10, 8'h99);
    send(1, 2'b11, 8'h00);
    drop(); wait_idle();
    send(1, 2'b01, 8'hFF); drop(); wait_idle();
    repeat (5) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule